// File: doc/BRIEF.md
# Pointer Masking Address Transformer

This block rewrites the upper bits of a 64-bit effective address before the address reaches translation or memory, so that software can keep tag bits in the top of a pointer. It holds three 2-bit masking-mode fields: one for the machine security configuration, one for the machine environment configuration and one for the supervisor environment configuration. Each field has its own write strobe and data input. Every write is legalized before it is stored.

The field that applies is chosen from the current privilege level and from whether supervisor mode exists. The translation mode then sets how the masked bits are filled. With bare (physical) addressing the masked bits become zero. With Sv39 or Sv48 (virtual) addressing each masked bit becomes a copy of the address bit just below the masked region. The address path is purely combinational. The mode fields are registered.

Top module: `ptr_mask_xform`

## Requirements
- R1: After reset all three mode fields hold 2'b00, and an active mode of 2'b00 passes the address through unchanged.
- R2: A write strobe stores its 2-bit value into its field at the next rising clock edge, provided the feature enable is high, XLEN is not 32 and the value is not 2'b01.
- R3: A write of the reserved value 2'b01 is ignored, and the field keeps its previous value.
- R4: While the feature enable is low, writes are ignored and every field stays at 2'b00.
- R5: With privilege code 3 (machine) the active mode is the machine security field. With privilege code 1 (supervisor) the active mode is the machine environment field.
- R6: With privilege code 0 (user) the active mode is the supervisor environment field when supervisor-present is 1, and the machine environment field when supervisor-present is 0.
- R7: Mode 2'b10 masks the top 7 address bits and mode 2'b11 masks the top 16 address bits.
- R8: With translation code 0 (bare) the masked bits are driven to zero and all lower bits pass through.
- R9: With translation code 1 (Sv39) or 2 (Sv48) each masked bit is a copy of address bit XLEN-PMLEN-1, and all lower bits pass through.
- R10: Translation code 3 and privilege code 2 both give no masking, so the address passes through unchanged.
- R11: The output follows a change of the address input in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Static enable for pointer masking |
| sup_present | input | 1 | Supervisor mode is implemented |
| priv | input | 2 | Privilege code: 3 machine, 1 supervisor, 0 user |
| xlat_mode | input | 2 | Translation code: 0 bare, 1 Sv39, 2 Sv48 |
| msec_we | input | 1 | Write strobe for the machine security mode field |
| msec_wd | input | 2 | Write data for the machine security mode field |
| menv_we | input | 1 | Write strobe for the machine environment mode field |
| menv_wd | input | 2 | Write data for the machine environment mode field |
| senv_we | input | 1 | Write strobe for the supervisor environment mode field |
| senv_wd | input | 2 | Write data for the supervisor environment mode field |
| addr_in | input | XLEN | Effective address before masking |
| addr_out | output | XLEN | Address after masking |

## Verification
The hardest case to reach is a field that has to hold its value: a reserved write, or any write while the feature is disabled. The stored field has no read port, so its value can only be seen through the address path. The bench first loads a field with a known masking mode. It then issues the write that should be rejected and sends an address through under the privilege that selects that field, so any change of the mask length or the fill appears at the output. It uses two addresses, chosen so that the sign-fill bits for the 7-bit and the 16-bit masks differ. This lets a wrong mask length be told apart from a wrong fill.

// File: rtl/ptr_mask_xform.sv
module ptr_mask_xform #(
  parameter int XLEN      = 64,
  parameter int LEN_SHORT = 7,
  parameter int LEN_LONG  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            feat_en,
  input  logic            sup_present,
  input  logic [1:0]      priv,
  input  logic [1:0]      xlat_mode,
  input  logic            msec_we,
  input  logic [1:0]      msec_wd,
  input  logic            menv_we,
  input  logic [1:0]      menv_wd,
  input  logic            senv_we,
  input  logic [1:0]      senv_wd,
  input  logic [XLEN-1:0] addr_in,
  output logic [XLEN-1:0] addr_out
);

  localparam logic            XLEN_OK = (XLEN != 32);
  localparam logic [XLEN-1:0] MASK_S  = ~({XLEN{1'b1}} >> LEN_SHORT);
  localparam logic [XLEN-1:0] MASK_L  = ~({XLEN{1'b1}} >> LEN_LONG);

  logic [1:0] msec_q, menv_q, senv_q;
  logic [1:0] act;
  logic       wr_ok, is_bare, is_virt, fill;
  logic [XLEN-1:0] mask;

  assign wr_ok = feat_en & XLEN_OK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msec_q <= 2'b00;
      menv_q <= 2'b00;
      senv_q <= 2'b00;
    end else begin
      if (msec_we && wr_ok && msec_wd != 2'b01) msec_q <= msec_wd;
      if (menv_we && wr_ok && menv_wd != 2'b01) menv_q <= menv_wd;
      if (senv_we && wr_ok && senv_wd != 2'b01) senv_q <= senv_wd;
    end
  end

  always_comb begin
    case (priv)
      2'd3:    act = msec_q;
      2'd1:    act = menv_q;
      2'd0:    act = sup_present ? senv_q : menv_q;
      default: act = 2'b00;
    endcase
  end

  assign is_bare = (xlat_mode == 2'd0);
  assign is_virt = (xlat_mode == 2'd1) || (xlat_mode == 2'd2);

  always_comb begin
    mask = '0;
    fill = 1'b0;
    if (is_bare || is_virt) begin
      case (act)
        2'b10: begin mask = MASK_S; fill = addr_in[XLEN-LEN_SHORT-1]; end
        2'b11: begin mask = MASK_L; fill = addr_in[XLEN-LEN_LONG-1];  end
        default: ;
      endcase
    end
  end

  assign addr_out = (addr_in & ~mask) | ({XLEN{fill & is_virt}} & mask);

  a_r1_r3_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (msec_q != 2'b01) && (menv_q != 2'b01) && (senv_q != 2'b01));

  a_r2_legal_write: assert property (@(posedge clk) disable iff (!rst_n)
    (msec_we && feat_en && XLEN_OK && msec_wd != 2'b01) |=> (msec_q == $past(msec_wd)));

  a_r4_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_en |=> ({msec_q, menv_q, senv_q} == $past({msec_q, menv_q, senv_q})));

  a_r8_bare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_mode == 2'd0 && act[1]) |-> (addr_out[XLEN-1 -: LEN_SHORT] == '0));

  a_r9_sign_long: assert property (@(posedge clk) disable iff (!rst_n)
    (is_virt && act == 2'b11) |->
      (addr_out[XLEN-1 -: LEN_LONG] == {LEN_LONG{addr_in[XLEN-LEN_LONG-1]}}));

  a_r10_unsupported_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_mode == 2'd3 || priv == 2'd2) |-> (addr_out == addr_in));

  a_r11_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
    addr_out[XLEN-LEN_LONG-1:0] == addr_in[XLEN-LEN_LONG-1:0]);

endmodule

// File: tb/ptr_mask_xform_tb.sv
`timescale 1ns/1ps
module ptr_mask_xform_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        feat_en = 1'b1;
  logic        sup_present = 1'b1;
  logic [1:0]  priv = 2'd3;
  logic [1:0]  xlat_mode = 2'd0;
  logic        msec_we = 1'b0, menv_we = 1'b0, senv_we = 1'b0;
  logic [1:0]  msec_wd = 2'b00, menv_wd = 2'b00, senv_wd = 2'b00;
  logic [63:0] addr_in = '0;
  logic [63:0] addr_out;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [63:0] A = 64'hA5C3_0080_1234_5678;
  localparam logic [63:0] B = 64'h1234_8000_0000_00FF;

  // {priv, sup_present, xlat_mode, addr, expected}
  // fields during the table: machine security 10, machine env 11, supervisor env 00
  localparam logic [132:0] TBL [12] = '{
    {2'd3, 1'b1, 2'd0, A, 64'h01C3_0080_1234_5678},
    {2'd3, 1'b1, 2'd1, A, 64'hFFC3_0080_1234_5678},
    {2'd3, 1'b1, 2'd2, B, 64'h0034_8000_0000_00FF},
    {2'd1, 1'b1, 2'd0, B, 64'h0000_8000_0000_00FF},
    {2'd1, 1'b1, 2'd2, B, 64'hFFFF_8000_0000_00FF},
    {2'd1, 1'b1, 2'd1, A, 64'h0000_0080_1234_5678},
    {2'd0, 1'b1, 2'd1, A, A},
    {2'd0, 1'b0, 2'd1, B, 64'hFFFF_8000_0000_00FF},
    {2'd3, 1'b1, 2'd3, A, A},
    {2'd2, 1'b1, 2'd1, B, B},
    {2'd0, 1'b0, 2'd0, A, 64'h0000_0080_1234_5678},
    {2'd1, 1'b0, 2'd1, B, 64'hFFFF_8000_0000_00FF}
  };

  ptr_mask_xform dut_i (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .sup_present(sup_present),
    .priv(priv), .xlat_mode(xlat_mode),
    .msec_we(msec_we), .msec_wd(msec_wd),
    .menv_we(menv_we), .menv_wd(menv_wd),
    .senv_we(senv_we), .senv_wd(senv_wd),
    .addr_in(addr_in), .addr_out(addr_out)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] exp);
    tests++;
    if (addr_out !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, addr_out, exp);
    end
  endtask

  task automatic apply(input logic [1:0] p, input logic s, input logic [1:0] x,
                       input logic [63:0] a);
    priv = p; sup_present = s; xlat_mode = x; addr_in = a;
    #1;
  endtask

  task automatic wr(input int sel, input logic [1:0] v);
    @(negedge clk);
    case (sel)
      0: begin msec_we = 1'b1; msec_wd = v; end
      1: begin menv_we = 1'b1; menv_wd = v; end
      default: begin senv_we = 1'b1; senv_wd = v; end
    endcase
    @(negedge clk);
    msec_we = 1'b0; menv_we = 1'b0; senv_we = 1'b0;
  endtask

  task automatic do_reset(input logic en);
    @(negedge clk);
    rst_n = 1'b0; feat_en = en;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    // R1: reset fields are 00, so every privilege passes through
    apply(2'd3, 1'b1, 2'd1, A); check("R1 machine after reset", A);
    apply(2'd1, 1'b1, 2'd0, B); check("R1 supervisor after reset", B);
    apply(2'd0, 1'b1, 2'd2, A); check("R1 user after reset", A);

    // R2: the value takes effect at the clock edge, not before
    apply(2'd3, 1'b1, 2'd1, A);
    @(negedge clk);
    msec_we = 1'b1; msec_wd = 2'b10;
    #1; check("R2 before edge", A);
    @(negedge clk);
    msec_we = 1'b0;
    #1; check("R2 after edge", 64'hFFC3_0080_1234_5678);
    wr(1, 2'b11);
    wr(2, 2'b00);

    // R5 R6 R7 R8 R9 R10: table walk
    foreach (TBL[i]) begin
      @(negedge clk);
      apply(TBL[i][132:131], TBL[i][130], TBL[i][129:128], TBL[i][127:64]);
      check($sformatf("R5/R6/R7/R8/R9/R10 vector %0d", i), TBL[i][63:0]);
    end

    // R3: a reserved write leaves machine security at 10
    wr(0, 2'b01);
    apply(2'd3, 1'b1, 2'd1, A); check("R3 reserved write ignored", 64'hFFC3_0080_1234_5678);
    wr(1, 2'b01);
    apply(2'd1, 1'b1, 2'd2, B); check("R3 reserved write ignored env", 64'hFFFF_8000_0000_00FF);

    // R11: the output follows the address with no clock edge in between
    @(negedge clk);
    apply(2'd1, 1'b1, 2'd2, A); check("R11 same cycle A", 64'h0000_0080_1234_5678);
    apply(2'd1, 1'b1, 2'd2, B); check("R11 same cycle B", 64'hFFFF_8000_0000_00FF);

    // R4: writes are ignored while the feature is disabled
    do_reset(1'b0);
    wr(0, 2'b11); wr(1, 2'b10); wr(2, 2'b11);
    apply(2'd3, 1'b1, 2'd1, B); check("R4 disabled machine", B);
    apply(2'd1, 1'b1, 2'd0, A); check("R4 disabled supervisor", A);
    apply(2'd0, 1'b1, 2'd1, B); check("R4 disabled user", B);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule